// File: doc/BRIEF.md
# HDLC Bit-Serial Frame Transmitter

This block turns bytes into an HDLC bit stream. A host pushes bytes into a 19-entry transmit queue one at a time, starting with the address byte. Each byte carries an end-of-frame tag and a force-abort qualifier. The transmitter wraps each frame between flags and appends a 16-bit frame check sequence (FCS). It then applies zero-bit insertion to the data and the FCS. One bit leaves on `tx_data` for every `bit_en` strobe. Inserted zeros use strobes like any other bit, so the rate at which bytes are fetched slows to match.

Between frames the line carries interframe fill, chosen by `flag_fill`. With `flag_fill` low the fill is continuous ones (idle). With `flag_fill` high the fill is back-to-back flags. The fill mode also decides how a frame opens. From idle, the byte of ones in progress completes, then an opening flag is sent. In flag fill, the flag already going out serves as the opening flag.

A byte written with the abort qualifier is replaced by an abort pattern, provided at least two bytes of the frame have already been sent. If the queue runs dry in mid-frame, the transmitter sends an abort and raises an underrun status.

Top module: `hdlc_tx_framer`

## Requirements
- R1: After reset `tx_data` is 1, `fifo_empty` is 1, `fifo_level` is 0 and `underrun` is 0. While `tx_enable` is low, no frame starts, the output stays all ones, and queued bytes stay in the queue.
- R2: The queue holds 19 entries. `fifo_level` counts them and `fifo_full` is high at 19. A write while full is dropped.
- R3: Fill is made of 8-bit fill bytes counted from reset. Each fill byte is all ones, or the flag 0x7E (bits sent 0,1,1,1,1,1,1,0). The kind of each byte is taken at the start of that byte from `tx_enable & flag_fill`. The first fill byte after reset is ones.
- R4: A frame starts only at the end of a fill byte that finds the queue non-empty with `tx_enable` high. If that fill byte was ones, an opening flag is sent next, then the data.
- R5: If that fill byte was a flag, it is the opening flag: the first data bit follows it directly.
- R6: Data bytes are sent least significant bit first. `tx_data` changes only in the cycle after a `bit_en` strobe, and it carries exactly one bit per strobe.
- R7: The FCS register is preset to 0xFFFF at frame start. Each data bit, in the order sent, is shifted in with generator x^16+x^12+x^5+1. After the byte tagged end-of-frame, the one's complement of the FCS is sent most significant bit first. A single closing flag follows, then fill resumes.
- R8: After every five consecutive ones in the data and the FCS, a 0 is inserted. This includes a run that ends at the last FCS bit or the last data bit before an abort. Flags, fill and abort patterns are never stuffed.
- R9: Take a queued byte carrying the abort qualifier, reached after at least two bytes of the frame have been sent. It is not sent. Instead the line carries 0 followed by seven ones, then fill resumes.
- R10: A byte carrying the abort qualifier that is reached after fewer than two bytes of the frame have been sent is sent as ordinary data.
- R11: Suppose the queue is empty when a byte that is not tagged end-of-frame finishes. Then an abort (0 then seven ones) is sent and `underrun` goes high. `underrun` stays high until the next frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one byte into the transmit queue |
| wr_data | input | 8 | Byte to queue |
| wr_eof | input | 1 | Marks the last byte of a frame |
| wr_abort | input | 1 | Replace this byte with an abort pattern |
| tx_enable | input | 1 | Allows frames to start |
| flag_fill | input | 1 | 1: flag fill between frames, 0: all-ones idle |
| bit_en | input | 1 | Bit strobe: advance the serial output by one bit |
| tx_data | output | 1 | Serial line output |
| fifo_level | output | 5 | Number of queued entries |
| fifo_full | output | 1 | Queue holds 19 entries |
| fifo_empty | output | 1 | Queue holds no entry |
| underrun | output | 1 | Last frame was cut short by an empty queue |

## Verification
The hardest cases to reach from the ports are the stuffed zeros at the edges of a frame. One sits between the last FCS bit and the closing flag. Another sits between the last data bit and an abort. Each needs a run of exactly five ones at that point.

The stimulus uses bytes full of ones (0xFF, 0x3F, 0x7E) so that runs cross byte and FCS boundaries. The bench rebuilds the whole expected line bit by bit from the queued bytes, including the strobe at which each frame opens. It then compares every recorded bit. Underrun is reached by queuing two untagged bytes, all written before the frame opens, so the queue is certainly empty when the second byte finishes.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam int BYTE_W = 8;
  localparam int FCS_W = 16;
  localparam int CNT_W = 4;
  localparam int RUN_W = 3;
  localparam int RUN_MAX = 5;
  localparam logic [BYTE_W-1:0] FLAG_PAT = 8'h7E;
  localparam logic [FCS_W-1:0] FCS_POLY = 16'h1021;
  localparam logic [FCS_W-1:0] FCS_PRESET = 16'hFFFF;

  typedef enum logic [2:0] {
    ST_FILL, ST_OPEN, ST_DATA, ST_FCS, ST_CLOSE, ST_ABORT
  } tx_state_e;

  typedef struct packed {
    logic             abort;
    logic             eof;
    logic [BYTE_W-1:0] data;
  } q_entry_t;

  function automatic logic [FCS_W-1:0] fcs_step(input logic [FCS_W-1:0] cur,
                                                input logic din);
    logic fb;
    fb = cur[FCS_W-1] ^ din;
    return {cur[FCS_W-2:0], 1'b0} ^ ({FCS_W{fb}} & FCS_POLY);
  endfunction

  function automatic logic flag_bit(input logic [2:0] idx);
    return FLAG_PAT[idx];
  endfunction
endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo import hdlc_tx_pkg::*; #(
  parameter int DEPTH = 19,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  q_entry_t         push_entry,
  input  logic             pop,
  output q_entry_t         head,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  q_entry_t         mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  assign full    = (level == FULL_LVL);
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/hdlc_tx_fcs.sv
module hdlc_tx_fcs import hdlc_tx_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             preset,
  input  logic             shift,
  input  logic             din,
  output logic [FCS_W-1:0] fcs_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fcs_q <= FCS_PRESET;
    else if (preset) fcs_q <= FCS_PRESET;
    else if (shift)  fcs_q <= fcs_step(fcs_q, din);
  end
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer import hdlc_tx_pkg::*; #(
  parameter int FIFO_DEPTH = 19,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              wr_eof,
  input  logic              wr_abort,
  input  logic              tx_enable,
  input  logic              flag_fill,
  input  logic              bit_en,
  output logic              tx_data,
  output logic [LVL_W-1:0]  fifo_level,
  output logic              fifo_full,
  output logic              fifo_empty,
  output logic              underrun
);
  localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FCS_LAST  = CNT_W'(FCS_W - 1);
  localparam logic [RUN_W-1:0] RUN_LIM   = RUN_W'(RUN_MAX);

  tx_state_e         st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic              cur_eof;
  logic              first_done;
  logic [RUN_W-1:0]  ones;
  logic              fill_q;
  logic              underrun_q;
  q_entry_t          head;
  q_entry_t          wr_entry;
  logic [FCS_W-1:0]  fcs_q;

  // Named events shared by the datapath and the checker
  logic stuff_now, emit_bit, body_bit, byte_end_8, fill_end;
  logic frame_start, go_open, data_byte_end, next_is_abort;
  logic abort_start, pop, fcs_shift;

  assign wr_entry = '{abort: wr_abort, eof: wr_eof, data: wr_data};

  hdlc_tx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (wr_en),
    .push_entry (wr_entry),
    .pop        (pop),
    .head       (head),
    .level      (fifo_level),
    .full       (fifo_full),
    .empty      (fifo_empty)
  );

  hdlc_tx_fcs u_fcs (
    .clk    (clk),
    .rst_n  (rst_n),
    .preset (frame_start),
    .shift  (fcs_shift),
    .din    (emit_bit),
    .fcs_q  (fcs_q)
  );

  assign stuff_now = bit_en && (ones == RUN_LIM) &&
                     ((st == ST_DATA) || (st == ST_FCS) ||
                      (((st == ST_CLOSE) || (st == ST_ABORT)) && (cnt == '0)));
  assign byte_end_8    = bit_en && !stuff_now && (cnt == BYTE_LAST);
  assign fill_end      = byte_end_8 && (st == ST_FILL);
  assign frame_start   = (fill_end && tx_enable && !fifo_empty && fill_q) ||
                         (byte_end_8 && (st == ST_OPEN));
  assign go_open       = fill_end && tx_enable && !fifo_empty && !fill_q;
  assign data_byte_end = byte_end_8 && (st == ST_DATA);
  assign next_is_abort = head.abort && first_done;
  assign abort_start   = data_byte_end && !cur_eof && (fifo_empty || next_is_abort);
  assign pop           = frame_start || (data_byte_end && !cur_eof && !fifo_empty);
  assign body_bit      = bit_en && ((st == ST_DATA) || (st == ST_FCS));
  assign fcs_shift     = bit_en && !stuff_now && (st == ST_DATA);

  always_comb begin
    if (stuff_now) emit_bit = 1'b0;
    else begin
      unique case (st)
        ST_FILL:  emit_bit = fill_q ? flag_bit(cnt[2:0]) : 1'b1;
        ST_OPEN,
        ST_CLOSE: emit_bit = flag_bit(cnt[2:0]);
        ST_DATA:  emit_bit = shreg[cnt[2:0]];
        ST_FCS:   emit_bit = ~fcs_q[FCS_LAST - cnt];
        ST_ABORT: emit_bit = (cnt != '0);
        default:  emit_bit = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_FILL;
      cnt        <= '0;
      shreg      <= '0;
      cur_eof    <= 1'b0;
      first_done <= 1'b0;
      ones       <= '0;
      fill_q     <= 1'b0;
      tx_data    <= 1'b1;
    end else if (bit_en) begin
      tx_data <= emit_bit;
      if (stuff_now) begin
        ones <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
        if ((st == ST_DATA) || (st == ST_FCS))
          ones <= emit_bit ? ones + RUN_W'(1) : '0;
        if (frame_start) begin
          st         <= ST_DATA;
          cnt        <= '0;
          shreg      <= head.data;
          cur_eof    <= head.eof;
          first_done <= 1'b0;
          ones       <= '0;
        end
        unique case (st)
          ST_FILL: if (cnt == BYTE_LAST) begin
            cnt    <= '0;
            fill_q <= tx_enable && flag_fill;
            if (go_open) st <= ST_OPEN;
          end
          ST_DATA: if (cnt == BYTE_LAST) begin
            cnt        <= '0;
            first_done <= 1'b1;
            if (cur_eof)          st <= ST_FCS;
            else if (abort_start) st <= ST_ABORT;
            else begin
              shreg   <= head.data;
              cur_eof <= head.eof;
            end
          end
          ST_FCS: if (cnt == FCS_LAST) begin
            cnt <= '0;
            st  <= ST_CLOSE;
          end
          ST_CLOSE, ST_ABORT: if (cnt == BYTE_LAST) begin
            cnt    <= '0;
            st     <= ST_FILL;
            fill_q <= tx_enable && flag_fill;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          underrun_q <= 1'b0;
    else if (frame_start)                underrun_q <= 1'b0;
    else if (abort_start && fifo_empty)  underrun_q <= 1'b1;
  end

  assign underrun = underrun_q;
endmodule

// File: rtl/hdlc_tx_framer_chk.sv
module hdlc_tx_framer_chk #(
  parameter int FIFO_DEPTH = 19,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_en,
  input logic             tx_data,
  input logic             wr_en,
  input logic             fifo_full,
  input logic             fifo_empty,
  input logic [LVL_W-1:0] fifo_level,
  input logic             pop,
  input logic             stuff_now,
  input logic             emit_bit,
  input logic             body_bit,
  input logic             underrun,
  input logic             abort_start,
  input logic             frame_start
);
  logic [3:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   run <= '0;
    else if (bit_en && body_bit)  run <= emit_bit ? run + 4'd1 : 4'd0;
    else if (bit_en)              run <= '0;
  end

  // R6
  hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_data));
  // R6
  one_bit_per_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |=> (tx_data == $past(emit_bit)));
  // R8
  stuffed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_now |=> !tx_data);
  // R8
  ones_run_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (body_bit && emit_bit) |-> (run < 4'd5));
  // R2
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LVL_W'(FIFO_DEPTH));
  // R2
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fifo_full && !pop) |=> (fifo_level == $past(fifo_level)));
  // R4
  start_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !fifo_empty);
  // R11
  underrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $past(abort_start));
  // R11
  underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_start && fifo_empty) |=> underrun);
endmodule

bind hdlc_tx_framer hdlc_tx_framer_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bit_en      (bit_en),
  .tx_data     (tx_data),
  .wr_en       (wr_en),
  .fifo_full   (fifo_full),
  .fifo_empty  (fifo_empty),
  .fifo_level  (fifo_level),
  .pop         (pop),
  .stuff_now   (stuff_now),
  .emit_bit    (emit_bit),
  .body_bit    (body_bit),
  .underrun    (underrun),
  .abort_start (abort_start),
  .frame_start (frame_start)
);

// File: tb/hdlc_tx_framer_bench.sv
module hdlc_tx_framer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAXB = 1024;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_eof = 1'b0, wr_abort = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic tx_enable = 1'b0, flag_fill = 1'b0, bit_en = 1'b0;
  logic tx_data, fifo_full, fifo_empty, underrun;
  logic [4:0] fifo_level;

  int total = 0, fails = 0;
  logic rec  [MAXB];
  logic expv [MAXB];
  int rec_n, exp_n, run_m;
  logic [15:0] crc_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_tx_framer u_hdlc_tx_framer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_eof(wr_eof), .wr_abort(wr_abort), .tx_enable(tx_enable),
    .flag_fill(flag_fill), .bit_en(bit_en), .tx_data(tx_data),
    .fifo_level(fifo_level), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .underrun(underrun)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic en, input logic ff);
    @(negedge clk);
    rst_n = 1'b0; tx_enable = en; flag_fill = ff; bit_en = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rec_n = 0; exp_n = 0;
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_en = 1'b1;
      @(negedge clk); bit_en = 1'b0;
      if (rec_n < MAXB) begin rec[rec_n] = tx_data; rec_n++; end
    end
  endtask

  task automatic put(input logic [7:0] d, input logic eof, input logic ab);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wr_eof = eof; wr_abort = ab;
    @(negedge clk);
    wr_en = 1'b0; wr_eof = 1'b0; wr_abort = 1'b0;
  endtask

  // expected-stream builder
  task automatic x_push(input logic b);
    if (exp_n < MAXB) begin expv[exp_n] = b; exp_n++; end
  endtask
  task automatic x_ones(input int n);
    for (int i = 0; i < n; i++) x_push(1'b1);
  endtask
  task automatic x_flag();
    x_push(1'b0); x_ones(6); x_push(1'b0);
  endtask
  task automatic x_abort();
    x_push(1'b0); x_ones(7);
  endtask
  task automatic x_begin();
    run_m = 0; crc_m = 16'hFFFF;
  endtask
  task automatic x_body(input logic b);
    x_push(b);
    run_m = b ? run_m + 1 : 0;
    if (run_m == 5) begin x_push(1'b0); run_m = 0; end
  endtask
  task automatic x_byte(input logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      logic top;
      top = crc_m[15] ^ d[i];
      crc_m = crc_m << 1;
      if (top) crc_m = crc_m ^ 16'h1021;
      x_body(d[i]);
    end
  endtask
  task automatic x_fcs();
    logic [15:0] v;
    v = ~crc_m;
    for (int i = 15; i >= 0; i--) x_body(v[i]);
  endtask
  task automatic x_pad(input logic flags);
    while (exp_n < rec_n) begin
      if (flags) x_flag(); else x_ones(8);
    end
  endtask

  task automatic cmp_stream(input string tag);
    int bad;
    bad = -1;
    total++;
    for (int i = 0; i < rec_n; i++)
      if (bad < 0 && rec[i] !== expv[i]) bad = i;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s: line bit %0d actual %0b expected %0b", tag, bad, rec[bad], expv[bad]);
    end
  endtask

  task automatic t_reset_state();
    do_reset(1'b0, 1'b0);
    @(negedge clk);
    chk("R1 tx_data after reset", tx_data, 1);
    chk("R1 fifo_empty after reset", fifo_empty, 1);
    chk("R1 level after reset", fifo_level, 0);
    chk("R1 underrun after reset", underrun, 0);
    chk("R2 full after reset", fifo_full, 0);
  endtask

  task automatic t_disabled();
    do_reset(1'b0, 1'b1);
    put(8'h00, 1'b1, 1'b0);
    strobes(40);
    x_ones(40);
    cmp_stream("R1 disabled line stays ones");
    chk("R1 disabled keeps byte queued", fifo_level, 1);
  endtask

  task automatic t_idle_frame();
    do_reset(1'b1, 1'b0);
    strobes(16);
    put(8'hFF, 1'b0, 1'b0); put(8'h3F, 1'b0, 1'b0); put(8'h81, 1'b1, 1'b0);
    strobes(240);
    x_ones(24); x_flag(); x_begin();
    x_byte(8'hFF); x_byte(8'h3F); x_byte(8'h81); x_fcs(); x_flag();
    x_pad(1'b0);
    cmp_stream("R3 R4 R6 R7 R8 idle-fill frame");
  endtask

  task automatic t_flag_frame();
    do_reset(1'b1, 1'b1);
    strobes(16);
    put(8'h03, 1'b0, 1'b0); put(8'h7E, 1'b0, 1'b0); put(8'hA5, 1'b1, 1'b0);
    strobes(240);
    x_ones(8); x_flag(); x_flag(); x_begin();
    x_byte(8'h03); x_byte(8'h7E); x_byte(8'hA5); x_fcs(); x_flag();
    x_pad(1'b1);
    cmp_stream("R3 R5 R7 R8 flag-fill frame");
  endtask

  task automatic t_forced_abort();
    do_reset(1'b1, 1'b1);
    strobes(16);
    put(8'h1F, 1'b0, 1'b0); put(8'hF8, 1'b0, 1'b0); put(8'h33, 1'b0, 1'b1);
    strobes(160);
    x_ones(8); x_flag(); x_flag(); x_begin();
    x_byte(8'h1F); x_byte(8'hF8); x_abort();
    x_pad(1'b1);
    cmp_stream("R9 R8 forced abort after two bytes");
    chk("R9 abort entry consumed", fifo_empty, 1);
  endtask

  task automatic t_early_abort_tag();
    do_reset(1'b1, 1'b1);
    strobes(16);
    put(8'h11, 1'b0, 1'b0); put(8'h22, 1'b0, 1'b1); put(8'h33, 1'b1, 1'b0);
    strobes(200);
    x_ones(8); x_flag(); x_flag(); x_begin();
    x_byte(8'h11); x_byte(8'h22); x_byte(8'h33); x_fcs(); x_flag();
    x_pad(1'b1);
    cmp_stream("R10 early abort tag sent as data");
  endtask

  task automatic t_underrun();
    do_reset(1'b1, 1'b1);
    strobes(16);
    put(8'hAA, 1'b0, 1'b0); put(8'hBB, 1'b0, 1'b0);
    strobes(120);
    x_ones(8); x_flag(); x_flag(); x_begin();
    x_byte(8'hAA); x_byte(8'hBB); x_abort();
    x_pad(1'b1);
    cmp_stream("R11 underrun sends abort");
    chk("R11 underrun raised", underrun, 1);
    put(8'h01, 1'b1, 1'b0);
    strobes(40);
    chk("R11 underrun cleared by next frame", underrun, 0);
  endtask

  task automatic t_full();
    do_reset(1'b1, 1'b1);
    for (int i = 0; i < 19; i++) put(8'((i * 37 + 5) & 255), (i == 18), 1'b0);
    put(8'h55, 1'b1, 1'b0);
    chk("R2 level at capacity", fifo_level, 19);
    chk("R2 full flag", fifo_full, 1);
    strobes(400);
    x_ones(8); x_flag(); x_begin();
    for (int i = 0; i < 19; i++) x_byte(8'((i * 37 + 5) & 255));
    x_fcs(); x_flag();
    x_pad(1'b1);
    cmp_stream("R2 R4 nineteen-byte frame, extra write dropped");
    chk("R2 queue drained", fifo_empty, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", total, fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_disabled();
    t_idle_frame();
    t_flag_frame();
    t_forced_abort();
    t_early_abort_tag();
    t_underrun();
    t_full();
    $display("[TB] %0d tests run, %0d failed", total, fails);
    $finish;
  end
endmodule